// File: doc/BRIEF.md
# Two-Channel Down-Counting Event Timer

The block provides two independent 24-bit countdown channels behind a single-cycle 32-bit register bus. A write strobe, byte address and write data are sampled on the rising clock edge, and read data is a combinational function of the address. Each channel has a control word and a reload value. The control word holds run, interrupt-enable, a two-bit mode field and an 8-bit divider. Channel 1 also exposes its running count through a read-only window. A shared status register keeps one sticky terminal-count flag per channel. The block has one level interrupt line, driven from channel 0 only.

Each channel is a two-state machine. In IDLE the count is frozen. In RUN a divider counts input cycles and the count steps down once every divider+1 cycles. These are the named transitions:
- START (IDLE or RUN to RUN): a control write with run set. It loads the reload value and clears the divider phase.
- STOP (RUN to IDLE): a control write with run clear. The count is kept.
- EXPIRE (RUN to IDLE): terminal count in single-shot mode. The count is left at zero.
- WRAP (RUN to RUN): terminal count in repeating mode. The count is reloaded.

Terminal count is the decrement step taken while the count is 1 or 0. A control write in the same cycle takes precedence over it.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The control word at byte offsets 0x00 (channel 0) and 0x04 (channel 1) reads back as follows: run in bit 30, interrupt enable in bit 29, mode in bits 28:27, divider in bits 7:0, and all other bits zero. The reload values at 0x08 and 0x0C read back in bits 23:0 with the upper bits zero.
- R3: A control write with bit 30 set loads the reload value and starts counting. A control write with bit 30 clear stops the count and holds its value.
- R4: While running, the count decreases by one every P+1 clock cycles, where P is the divider. The first step comes P+1 cycles after the starting write.
- R5: In single-shot mode (mode 00), terminal count sets the channel's status flag, clears run and leaves the count at zero.
- R6: In repeating mode (mode 01), terminal count sets the flag, reloads the count from the reload value and keeps run set. The period is N·(P+1) cycles for a reload value N of 1 or more.
- R7: The status register at 0x18 has the channel 0 flag in bit 0 and the channel 1 flag in bit 1. Writing 1 to a bit clears that bit, writing 0 leaves it unchanged, and writing 0x1F clears both.
- R8: A flag is set at terminal count whether or not interrupts are enabled. `irq` equals the channel 0 flag AND the channel 0 interrupt enable.
- R9: Offset 0x14 returns channel 1's live count in bits 23:0. Writes to 0x14 are ignored, and unmapped offsets read zero.
- R10: The channels are independent: one channel's activity changes neither the other's flag nor its count.
- R11: A reload value of 0 behaves as 1: terminal count comes at the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt for channel 0 |

## Verification
A wrong channel state shows on the bus at once. A channel stuck in RUN or IDLE gives a wrong bit 30 on the next read of its control word. For channel 1 it also gives a count that moves, or fails to move, within P+1 cycles. A wrong divider phase or count is visible in channel 1's live window within one divider period. For channel 0 it shows as a status flag that rises one or more cycles early or late. Flags and `irq` are registered, so any error in terminal-count detection appears one edge after the faulty step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam logic [1:0] MODE_SINGLE    = 2'b00;
    localparam logic [1:0] MODE_REPEATING = 2'b01;

    localparam int RUN_BIT  = 30;
    localparam int IEN_BIT  = 29;
    localparam int MODE_HI  = 28;
    localparam int MODE_LO  = 27;

    localparam logic [7:0] OFS_CTRL_BASE = 8'h00;
    localparam logic [7:0] OFS_LOAD_BASE = 8'h08;
    localparam logic [7:0] OFS_LIVE1     = 8'h14;
    localparam logic [7:0] OFS_STATUS    = 8'h18;

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_run,
    input  logic             cfg_ien,
    input  logic [1:0]       cfg_mode,
    input  logic [PRE_W-1:0] cfg_pre,
    input  logic [CNT_W-1:0] load_val,
    output logic             run,
    output logic             ien,
    output logic             repeating,
    output logic [1:0]       mode,
    output logic [PRE_W-1:0] pre,
    output logic [CNT_W-1:0] count,
    output logic             tc
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [PRE_W-1:0] phase_q, phase_d;
    logic             ien_q;
    logic [1:0]       mode_q;
    logic [PRE_W-1:0] pre_q;
    logic             step;
    logic             last;

    assign step = (state_q == CH_RUN) && (phase_q == pre_q);
    assign last = (count_q <= CNT_W'(1));

    // next-state process
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        phase_d = phase_q;
        if (cfg_we) begin
            phase_d = '0;
            if (cfg_run) begin
                state_d = CH_RUN;      // START
                count_d = load_val;
            end else begin
                state_d = CH_IDLE;     // STOP
            end
        end else begin
            unique case (state_q)
                CH_IDLE: ;
                CH_RUN: begin
                    if (step) begin
                        phase_d = '0;
                        if (!last) begin
                            count_d = count_q - CNT_W'(1);
                        end else if (mode_q == MODE_REPEATING) begin
                            count_d = load_val;   // WRAP
                        end else begin
                            count_d = '0;         // EXPIRE
                            state_d = CH_IDLE;
                        end
                    end else begin
                        phase_d = phase_q + PRE_W'(1);
                    end
                end
                default: state_d = CH_IDLE;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            count_q <= '0;
            phase_q <= '0;
            ien_q   <= 1'b0;
            mode_q  <= MODE_SINGLE;
            pre_q   <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            phase_q <= phase_d;
            if (cfg_we) begin
                ien_q  <= cfg_ien;
                mode_q <= cfg_mode;
                pre_q  <= cfg_pre;
            end
        end
    end

    // output process
    always_comb begin
        run       = (state_q == CH_RUN);
        ien       = ien_q;
        mode      = mode_q;
        repeating = (mode_q == MODE_REPEATING);
        pre       = pre_q;
        count     = count_q;
        tc        = step && last && !cfg_we;
    end

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 24,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0]                 ch_run, ch_ien, ch_periodic, ch_tc, ch_ctrl_we;
    logic [NUM_CH-1:0][1:0]            ch_mode;
    logic [NUM_CH-1:0][PRE_W-1:0]      ch_pre;
    logic [NUM_CH-1:0][CNT_W-1:0]      ch_count;
    logic [NUM_CH-1:0][CNT_W-1:0]      load_q;
    logic [NUM_CH-1:0]                 flag_q;
    logic                              status_we;

    assign status_we = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(OFS_CTRL_BASE) + ADDR_W'(4*i);
        localparam logic [ADDR_W-1:0] LOAD_A = ADDR_W'(OFS_LOAD_BASE) + ADDR_W'(4*i);

        assign ch_ctrl_we[i] = bus_we && (bus_addr == CTRL_A);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                load_q[i] <= '0;
                flag_q[i] <= 1'b0;
            end else begin
                if (bus_we && (bus_addr == LOAD_A)) begin
                    load_q[i] <= bus_wdata[CNT_W-1:0];
                end
                flag_q[i] <= (flag_q[i] && !(status_we && bus_wdata[i])) || ch_tc[i];
            end
        end

        tmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (ch_ctrl_we[i]),
            .cfg_run   (bus_wdata[RUN_BIT]),
            .cfg_ien   (bus_wdata[IEN_BIT]),
            .cfg_mode  (bus_wdata[MODE_HI:MODE_LO]),
            .cfg_pre   (bus_wdata[PRE_W-1:0]),
            .load_val  (load_q[i]),
            .run       (ch_run[i]),
            .ien       (ch_ien[i]),
            .repeating (ch_periodic[i]),
            .mode      (ch_mode[i]),
            .pre       (ch_pre[i]),
            .count     (ch_count[i]),
            .tc        (ch_tc[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(OFS_CTRL_BASE) + ADDR_W'(4*i)) begin
                bus_rdata[RUN_BIT]         = ch_run[i];
                bus_rdata[IEN_BIT]         = ch_ien[i];
                bus_rdata[MODE_HI:MODE_LO] = ch_mode[i];
                bus_rdata[PRE_W-1:0]       = ch_pre[i];
            end
            if (bus_addr == ADDR_W'(OFS_LOAD_BASE) + ADDR_W'(4*i)) begin
                bus_rdata[CNT_W-1:0] = load_q[i];
            end
        end
        if (bus_addr == ADDR_W'(OFS_LIVE1)) begin
            bus_rdata[CNT_W-1:0] = ch_count[1];
        end
        if (bus_addr == ADDR_W'(OFS_STATUS)) begin
            bus_rdata[NUM_CH-1:0] = flag_q;
        end
    end

    assign irq = flag_q[0] && ch_ien[0];

    logic unused_bits;
    assign unused_bits = ^{bus_wdata[31], bus_wdata[26:PRE_W], ch_periodic, ch_count[0]};

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic              run0,
    input logic              ien0,
    input logic              rep0,
    input logic              tc0,
    input logic              flag0,
    input logic [CNT_W-1:0]  count0,
    input logic [CNT_W-1:0]  load0
);

    logic ctrl0_wr;
    logic stat0_clr;
    assign ctrl0_wr  = bus_we && (bus_addr == ADDR_W'(8'h00));
    assign stat0_clr = bus_we && (bus_addr == ADDR_W'(8'h18)) && bus_wdata[0];

    // R3
    p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl0_wr && !bus_wdata[30] |=> !run0);

    // R4
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run0 && !ctrl0_wr && !tc0 |=> (count0 == $past(count0)) || (count0 == $past(count0) - CNT_W'(1)));

    // R5
    p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tc0 && !rep0 |=> !run0 && (count0 == '0));

    // R6
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tc0 && rep0 |=> run0 && (count0 == $past(load0)));

    // R7
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag0 && !stat0_clr |=> flag0);

    // R8
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc0 |=> flag0);

    // R8
    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag0 && ien0);

endmodule

bind dual_countdown_timer tmr_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run0      (ch_run[0]),
    .ien0      (ch_ien[0]),
    .rep0      (ch_periodic[0]),
    .tc0       (ch_tc[0]),
    .flag0     (flag_q[0]),
    .count0    (ch_count[0]),
    .load0     (load_q[0])
);

// File: tb/dual_countdown_timer_tb.sv
`timescale 1ns/1ps
module dual_countdown_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_countdown_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    localparam logic [31:0] RUN = 32'h4000_0000;
    localparam logic [31:0] IEN = 32'h2000_0000;
    localparam logic [31:0] REP = 32'h0800_0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a <= 8'h1C; a += 4) begin
            rd(8'(a), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_layout;
        logic [31:0] v;
        wr(8'h04, 32'hA800_FF5A);
        rd(8'h04, v); chk("R2 ctrl fields", v, 32'h2800_005A);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, v); chk("R2 load width", v, 32'h00FF_FFFF);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_run_stop;
        logic [31:0] v, v2;
        wr(8'h0C, 32'd100);
        wr(8'h04, RUN | 32'd3);
        wait_edges(8);
        rd(8'h14, v); chk("R4 after 8 cycles P=3", v, 32'd98);
        wait_edges(4);
        rd(8'h14, v); chk("R4 after 12 cycles P=3", v, 32'd97);
        rd(8'h04, v); chk("R3 run bit set", v, RUN | 32'd3);
        wr(8'h04, 32'h0);
        rd(8'h14, v); chk("R3 stop holds count", v, 32'd97);
        wait_edges(10);
        rd(8'h14, v2); chk("R3 stays stopped", v2, 32'd97);
        rd(8'h04, v); chk("R3 run bit clear", v, 32'h0);
    endtask

    task automatic t_single;
        logic [31:0] v;
        wr(8'h08, 32'd5);
        wr(8'h00, RUN);
        wait_edges(4);
        rd(8'h18, v); chk("R5 no flag before terminal", v, 32'h0);
        wait_edges(1);
        rd(8'h18, v); chk("R5 flag at terminal", v, 32'h1);
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        rd(8'h00, v); chk("R5 run cleared", v, 32'h0);
        wr(8'h00, IEN);
        chk("R8 irq with enable", {31'b0, irq}, 32'h1);
        wr(8'h18, 32'h2);
        rd(8'h18, v); chk("R7 zero bit leaves flag", v, 32'h1);
        chk("R7 irq kept", {31'b0, irq}, 32'h1);
        wr(8'h18, 32'h1);
        rd(8'h18, v); chk("R7 one bit clears flag", v, 32'h0);
        chk("R8 irq drops", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_repeat;
        logic [31:0] v;
        wr(8'h0C, 32'd3);
        wr(8'h04, RUN | REP | 32'd1);
        wait_edges(4);
        rd(8'h14, v); chk("R6 count mid period", v, 32'd1);
        rd(8'h18, v); chk("R6 no flag yet", v, 32'h0);
        wait_edges(2);
        rd(8'h14, v); chk("R6 reloaded", v, 32'd3);
        rd(8'h18, v); chk("R10 only channel 1 flag", v, 32'h2);
        wait_edges(2);
        rd(8'h14, v); chk("R6 keeps counting", v, 32'd2);
        wait_edges(4);
        rd(8'h14, v); chk("R6 second wrap", v, 32'd3);
        rd(8'h04, v); chk("R6 run stays set", v, RUN | REP | 32'd1);
        rd(8'h00, v); chk("R10 channel 0 idle", v, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h18, 32'h1F);
    endtask

    task automatic t_clear_all;
        logic [31:0] v;
        wr(8'h08, 32'd1);
        wr(8'h0C, 32'd1);
        wr(8'h00, RUN);
        wr(8'h04, RUN);
        wait_edges(3);
        rd(8'h18, v); chk("R7 both flags", v, 32'h3);
        wr(8'h18, 32'h1F);
        rd(8'h18, v); chk("R7 0x1F clears all", v, 32'h0);
    endtask

    task automatic t_window;
        logic [31:0] v;
        wr(8'h14, 32'h00AB_CDEF);
        rd(8'h14, v); chk("R9 write to live ignored", v, 32'h0);
        rd(8'h0C, v); chk("R9 load untouched", v, 32'd1);
        rd(8'h10, v); chk("R9 unmapped 0x10", v, 32'h0);
        rd(8'h1C, v); chk("R9 unmapped 0x1C", v, 32'h0);
    endtask

    task automatic t_zero_load;
        logic [31:0] v;
        wr(8'h0C, 32'd0);
        wr(8'h04, RUN | 32'd2);
        wait_edges(2);
        rd(8'h18, v); chk("R11 no flag before first step", v, 32'h0);
        wait_edges(1);
        rd(8'h18, v); chk("R11 flag at first step", v, 32'h2);
        rd(8'h14, v); chk("R11 count zero", v, 32'h0);
        wr(8'h18, 32'h1F);
    endtask

    initial begin
        #100_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_edges(3);
        rst_n = 1'b1;
        wait_edges(1);
        t_reset();
        t_layout();
        t_run_stop();
        t_single();
        t_repeat();
        t_clear_all();
        t_window();
        t_zero_load();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule